// File: doc/BRIEF.md
# Overcurrent and Thermal Fault Supervisor

This block decides when a switching regulator's power stage may run. It watches a per-switching-cycle current-limit flag (qualified by a cycle strobe), a short-circuit detect, and two temperature comparator flags: one for the hot trip point and one for the cool-down point. From these it drives a power-stage enable, a soft-start request and a select for a reduced current limit. The analog sensing and the soft-start ramp itself live elsewhere.

A run of current-limited switching cycles longer than a set count is treated as a sustained overcurrent. The supervisor then turns the stage off for a timed rest period and retries through a fresh soft-start. If the fault is still present, the count trips again and the retry loop repeats. A short circuit seen during soft-start selects the reduced current limit for the rest of that soft-start.

Over-temperature overrides everything. The stage stays off until the cool-down comparator reports that the die has dropped below the lower threshold, and restart always goes through soft-start. Time is counted in microsecond ticks derived from the clock with a prescaler.

States:
- `FS_SOFTSTART`: stage on, soft-start requested. Entered from reset, from a finished rest period or from a cooled die.
- `FS_RUN`: stage on. Entered when the soft-start time expires.
- `FS_OC_OFF`: stage off, rest timer running. Entered on a streak trip.
- `FS_THERM_OFF`: stage off. Entered whenever the die is hot.

Transitions, by priority:
1. Hot, from any state, goes to `FS_THERM_OFF`.
2. Streak trip, from `FS_SOFTSTART` or `FS_RUN`, goes to `FS_OC_OFF`.
3. Timer expiry moves `FS_SOFTSTART` to `FS_RUN` and `FS_OC_OFF` to `FS_SOFTSTART`.
4. Cool and not hot moves `FS_THERM_OFF` to `FS_SOFTSTART`.

Top module: `oc_thermal_supervisor`

## Requirements
- R1: Reset puts the block in soft-start: stage_en=1, ss_req=1, ilim_low=0. Soft-start lasts exactly SS_US*CLK_PER_US clock cycles from reset release, after which ss_req=0 and stage_en=1.
- R2: While the stage is on, a strobe with ilim_hit=1 that arrives after OC_TRIP_CYCLES consecutive limited strobes is a trip. The trip is the (OC_TRIP_CYCLES+1)-th consecutive one, and stage_en is 0 from the next cycle.
- R3: A strobe with ilim_hit=0 clears the consecutive count. Two runs of OC_TRIP_CYCLES limited strobes split by one clean strobe cause no trip.
- R4: ilim_hit has no effect on clock cycles where cyc_strobe=0. It neither adds to the count nor clears it.
- R5: After a trip, stage_en and ss_req stay 0 for exactly OFF_US*CLK_PER_US cycles. Then the block enters soft-start (stage_en=1, ss_req=1).
- R6: The count restarts from zero after each rest period. If every strobe is limited, the next trip comes on the (OC_TRIP_CYCLES+1)-th strobe after the retry.
- R7: short_det=1 sampled during soft-start sets ilim_low=1 from the next cycle until soft-start ends. ilim_low is 0 outside soft-start, and it starts at 0 on each new soft-start.
- R8: ot_hot=1 sampled in any state forces stage_en=0 and ss_req=0 from the next cycle.
- R9: After a thermal shutdown the stage stays off while ot_cool=0, even with ot_hot=0. A cycle with ot_cool=1 and ot_hot=0 starts soft-start on the next cycle.
- R10: Thermal shutdown takes precedence over the rest timer. Once hot is seen during a rest period, no retry happens when that period would have ended.
- R11: The power stage only ever turns on through soft-start: a rise of stage_en comes with ss_req=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | One-cycle pulse per switching cycle that qualifies ilim_hit |
| ilim_hit | input | 1 | Current limit reached in this switching cycle |
| short_det | input | 1 | Short-circuit detect |
| ot_hot | input | 1 | Die above the upper thermal threshold |
| ot_cool | input | 1 | Die below the lower thermal threshold |
| stage_en | output | 1 | Power-stage enable |
| ss_req | output | 1 | Soft-start request |
| ilim_low | output | 1 | Select the reduced current limit |

## Verification
All three outputs decode registered state, so no input reaches them in the same cycle. A trip, a hot flag, a cool release or a short flag sampled at one edge shows on the outputs at the next sample, one cycle later. The timed states last exactly their microsecond count times the prescaler. The bench drives inputs on the falling edge and samples outputs on the falling edge. Its cycle model moves on the same rising edges as the design, so every comparison falls at the cycle where the requirement puts the change, and directed duration checks count those samples exactly.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
    typedef enum logic [1:0] {
        FS_SOFTSTART = 2'd0,
        FS_RUN       = 2'd1,
        FS_OC_OFF    = 2'd2,
        FS_THERM_OFF = 2'd3
    } fsup_state_e;
endpackage

// File: rtl/fsup_us_timer.sv
// Microsecond-based interval timer: a cycle prescaler feeding a microsecond
// down-counter. The expire pulse marks the edge that closes the interval.
module fsup_us_timer #(
    parameter int CLK_PER_US = 250,
    parameter int US_W       = 8,
    parameter int INIT_US    = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [US_W-1:0] load_us,
    output logic            expire
);
    localparam int PW = $clog2(CLK_PER_US + 1);

    logic [PW-1:0]   pre_q;
    logic [US_W-1:0] us_q;
    logic            wrap;

    assign wrap   = (pre_q == PW'(CLK_PER_US - 1));
    assign expire = wrap && (us_q == US_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= US_W'(INIT_US);
        end else if (load) begin
            pre_q <= '0;
            us_q  <= load_us;
        end else if (wrap) begin
            pre_q <= '0;
            if (us_q != '0) us_q <= us_q - US_W'(1);
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end
endmodule

// File: rtl/fsup_streak_ctr.sv
// Counts consecutive current-limited switching cycles while the stage runs.
module fsup_streak_ctr #(
    parameter int TRIP = 32,
    localparam int W   = $clog2(TRIP + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         strobe,
    input  logic         hit,
    output logic         trip,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!enable) begin
            count <= '0;
        end else if (strobe) begin
            if (!hit)                   count <= '0;
            else if (count != W'(TRIP)) count <= count + W'(1);
        end
    end

    assign trip = enable && strobe && hit && (count == W'(TRIP));
endmodule

// File: rtl/oc_thermal_supervisor.sv
module oc_thermal_supervisor
    import fsup_pkg::*;
#(
    parameter int CLK_PER_US     = 250,
    parameter int OC_TRIP_CYCLES = 32,
    parameter int OFF_US         = 80,
    parameter int SS_US          = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_strobe,
    input  logic ilim_hit,
    input  logic short_det,
    input  logic ot_hot,
    input  logic ot_cool,
    output logic stage_en,
    output logic ss_req,
    output logic ilim_low
);
    localparam int MAX_US = (OFF_US > SS_US) ? OFF_US : SS_US;
    localparam int US_W   = $clog2(MAX_US + 1);
    localparam int SW     = $clog2(OC_TRIP_CYCLES + 1);

    fsup_state_e     state_q, state_d;
    logic            tmr_load, tmr_expire, oc_trip, short_q, run_on;
    logic [US_W-1:0] tmr_val;
    logic [SW-1:0]   streak_q;

    assign run_on = (state_q == FS_SOFTSTART) || (state_q == FS_RUN);

    fsup_streak_ctr #(.TRIP(OC_TRIP_CYCLES)) streak_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (run_on),
        .strobe (cyc_strobe),
        .hit    (ilim_hit),
        .trip   (oc_trip),
        .count  (streak_q)
    );

    assign tmr_load = (state_d != state_q) &&
                      ((state_d == FS_SOFTSTART) || (state_d == FS_OC_OFF));
    assign tmr_val  = (state_d == FS_OC_OFF) ? US_W'(OFF_US) : US_W'(SS_US);

    fsup_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W), .INIT_US(SS_US)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_us (tmr_val),
        .expire  (tmr_expire)
    );

    // Next-state logic: hot > streak trip > timer expiry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_SOFTSTART: begin
                if (ot_hot)          state_d = FS_THERM_OFF;
                else if (oc_trip)    state_d = FS_OC_OFF;
                else if (tmr_expire) state_d = FS_RUN;
            end
            FS_RUN: begin
                if (ot_hot)          state_d = FS_THERM_OFF;
                else if (oc_trip)    state_d = FS_OC_OFF;
            end
            FS_OC_OFF: begin
                if (ot_hot)          state_d = FS_THERM_OFF;
                else if (tmr_expire) state_d = FS_SOFTSTART;
            end
            FS_THERM_OFF: begin
                if (ot_cool && !ot_hot) state_d = FS_SOFTSTART;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_SOFTSTART;
        else        state_q <= state_d;
    end

    // Sticky short flag, cleared at each soft-start entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          short_q <= 1'b0;
        else if (tmr_load && (state_d == FS_SOFTSTART))      short_q <= 1'b0;
        else if ((state_q == FS_SOFTSTART) && short_det)     short_q <= 1'b1;
    end

    always_comb begin
        stage_en = 1'b0;
        ss_req   = 1'b0;
        ilim_low = 1'b0;
        unique case (state_q)
            FS_SOFTSTART: begin
                stage_en = 1'b1;
                ss_req   = 1'b1;
                ilim_low = short_q;
            end
            FS_RUN:       stage_en = 1'b1;
            FS_OC_OFF:    stage_en = 1'b0;
            FS_THERM_OFF: stage_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
    parameter int TRIP = 32,
    localparam int W   = $clog2(TRIP + 1)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cyc_strobe,
    input logic         ilim_hit,
    input logic         ot_hot,
    input logic         stage_en,
    input logic         ss_req,
    input logic         ilim_low,
    input logic [W-1:0] streak
);
    assert_trip_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && ilim_hit && stage_en && streak == W'(TRIP)) |=> !stage_en);

    assert_clean_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && !ilim_hit) |=> (streak == '0));

    assert_lowlim_in_ss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_low |-> ss_req);

    assert_hot_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ot_hot |=> (!stage_en && !ss_req));

    assert_start_via_ss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_en) |-> ss_req);

    assert_ss_has_stage_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req |-> stage_en);
endmodule

bind oc_thermal_supervisor fsup_checker #(.TRIP(OC_TRIP_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_strobe (cyc_strobe),
    .ilim_hit   (ilim_hit),
    .ot_hot     (ot_hot),
    .stage_en   (stage_en),
    .ss_req     (ss_req),
    .ilim_low   (ilim_low),
    .streak     (streak_q)
);

// File: tb/oc_thermal_supervisor_tb_top.sv
`timescale 1ns/1ps
module oc_thermal_supervisor_tb_top;
    localparam int CPU  = 4;
    localparam int TRIP = 32;
    localparam int OFFU = 20;
    localparam int SSU  = 5;
    localparam int SS_N  = SSU * CPU;
    localparam int OFF_N = OFFU * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 0, hit = 0, short_d = 0, hot = 0, cool = 0;
    logic stage_en, ss_req, ilim_low;

    int checks = 0, fails = 0, wd = 0;
    string cur_tag = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    oc_thermal_supervisor #(.CLK_PER_US(CPU), .OC_TRIP_CYCLES(TRIP),
                            .OFF_US(OFFU), .SS_US(SSU)) dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(strobe), .ilim_hit(hit),
        .short_det(short_d), .ot_hot(hot), .ot_cool(cool),
        .stage_en(stage_en), .ss_req(ss_req), .ilim_low(ilim_low));

    // Cycle model built from the requirements: 0 soft-start, 1 run, 2 rest, 3 thermal.
    int ms, left, cnt;
    bit flag;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; left = SS_N; cnt = 0; flag = 0;
        end else begin
            int ns;
            bit en, trp;
            en = (ms <= 1);
            trp = 0;
            if (en && strobe) begin
                if (hit) begin
                    if (cnt == TRIP) trp = 1; else cnt++;
                end else cnt = 0;
            end
            if (!en) cnt = 0;
            ns = ms;
            case (ms)
                0: if (hot) ns = 3; else if (trp) ns = 2; else if (left == 1) ns = 1;
                1: if (hot) ns = 3; else if (trp) ns = 2;
                2: if (hot) ns = 3; else if (left == 1) ns = 0;
                default: if (cool && !hot) ns = 0;
            endcase
            if (ns == 0 && ms != 0) flag = 0;
            else if (ms == 0 && short_d) flag = 1;
            if (ns != ms && ns == 0) left = SS_N;
            else if (ns != ms && ns == 2) left = OFF_N;
            else if (left > 1) left--;
            ms = ns;
        end
    end

    function automatic logic [2:0] model_out(int s, bit f);
        return {s <= 1, s == 0, (s == 0) && f};
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [2:0] e;
            e = model_out(ms, flag);
            check({stage_en, ss_req, ilim_low} == e, cur_tag, "model {en,ss,low}",
                  int'({stage_en, ss_req, ilim_low}), int'(e));
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            report();
        end
    end

    task automatic drive(bit s, bit h);
        strobe = s;
        hit = h;
        @(negedge clk);
    endtask

    initial begin
        int n;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1;
        check(stage_en && ss_req && !ilim_low, "R1", "reset outputs",
              int'({stage_en, ss_req, ilim_low}), 6);
        repeat (SS_N - 1) drive(0, 0);
        check(ss_req == 1, "R1", "still soft-start", int'(ss_req), 1);
        drive(0, 0);
        check(ss_req == 0 && stage_en == 1, "R1", "run after soft-start",
              int'({stage_en, ss_req}), 2);

        cur_tag = "R3";
        repeat (TRIP) drive(1, 1);
        drive(1, 0);
        repeat (TRIP) drive(1, 1);
        check(stage_en == 1, "R3", "no trip across clean strobe", int'(stage_en), 1);

        cur_tag = "R4";
        repeat (50) drive(0, 1);
        check(stage_en == 1, "R4", "unstrobed hits ignored", int'(stage_en), 1);
        cur_tag = "R2";
        drive(1, 1);
        check(stage_en == 0, "R2", "trip on 33rd limited strobe", int'(stage_en), 0);

        cur_tag = "R5";
        n = 1;
        strobe = 0; hit = 0;
        while (stage_en == 0 && n < 10000) begin drive(0, 0); if (stage_en == 0) n++; end
        check(n == OFF_N, "R5", "rest period cycles", n, OFF_N);
        check(ss_req == 1 && stage_en == 1, "R5", "retry soft-start",
              int'({stage_en, ss_req}), 3);

        cur_tag = "R6";
        n = 0;
        while (stage_en == 1 && n < 10000) begin drive(1, 1); n++; end
        check(n == TRIP + 1, "R6", "strobes to second trip", n, TRIP + 1);
        drive(0, 0);
        while (ss_req == 0 && wd < 100000) drive(0, 0);

        cur_tag = "R7";
        short_d = 1; drive(0, 0); short_d = 0;
        check(ilim_low == 1, "R7", "short selects low limit", int'(ilim_low), 1);
        drive(0, 0);
        check(ilim_low == 1, "R7", "low limit held", int'(ilim_low), 1);
        while (ss_req == 1 && wd < 100000) drive(0, 0);
        check(ilim_low == 0, "R7", "low limit off in run", int'(ilim_low), 0);

        cur_tag = "R8";
        hot = 1; drive(0, 0); hot = 0;
        check(stage_en == 0 && ss_req == 0, "R8", "hot shutdown",
              int'({stage_en, ss_req}), 0);
        cur_tag = "R9";
        repeat (30) drive(0, 0);
        check(stage_en == 0, "R9", "held off until cool", int'(stage_en), 0);
        cool = 1; drive(0, 0); cool = 0;
        check(stage_en && ss_req, "R9", "restart on cool", int'({stage_en, ss_req}), 3);

        cur_tag = "R10";
        while (ss_req == 1 && wd < 100000) drive(0, 0);
        repeat (TRIP + 1) drive(1, 1);
        check(stage_en == 0, "R10", "tripped before hot", int'(stage_en), 0);
        hot = 1; drive(0, 0); hot = 0;
        repeat (OFF_N + 40) drive(0, 0);
        check(stage_en == 0, "R10", "no retry after hot", int'(stage_en), 0);
        cool = 1; drive(0, 0); cool = 0;
        check(stage_en && ss_req, "R10", "cool restart", int'({stage_en, ss_req}), 3);

        cur_tag = "R11";
        for (int i = 0; i < 6000; i++) begin
            bool_step(i);
        end
        report();
    end

    task automatic bool_step(int i);
        strobe  = $urandom % 2;
        hit     = ((i / 250) % 2 == 0) ? 1'b1 : (($urandom % 8) != 0);
        short_d = ($urandom % 16) == 0;
        hot     = ($urandom % 400) == 0;
        cool    = ($urandom % 4) == 0;
        @(negedge clk);
    endtask
endmodule